// File: doc/BRIEF.md
# Multi-Write-Port Memory with Per-Clock-Group Write Ordering

This block is a synchronous storage array with several read ports and several write ports. Every read port has its own clock. Every write port has an enable, a mask, an address and a data word, and is attached to one of a set of write clock inputs. The parameter `WR_GROUP` names that clock for each write port. Write ports that name the same clock form a group.

The parameter `ORDERED` picks how the block resolves writes that collide. When `ORDERED` is 1, each group applies its writes in one update per edge, in ascending write-port index. If ports collide on an address, the port with the highest index wins. When `ORDERED` is 0, every write port updates storage on its own and the result of a same-address collision is unspecified. Ports are counted with the read ports first and the write ports after them. Priority is ranked by the index among the write ports only.

Each read port registers its request on its own clock and returns data one cycle later. A read and a write to the same address on the same edge return the word held before that write. The stored contents are not reset. Only the read output registers are reset, synchronously, by `rst`.

Top module: `mwm_mem`

## Requirements
- R1: With `ORDERED`=1, when two or more enabled and masked write ports of one group hit the same address on one edge, a later read returns the data of the port with the highest write index among them.
- R2: With `ORDERED`=0, write ports that share a clock and target different addresses on one edge each store their own data.
- R3: Writes on different clock groups have no fixed priority. The last write to land at an address is the one read back, whatever the port indices.
- R4: A write port changes storage only when both `wr_en` and `wr_mask` of that port are 1 at its clock edge. If either is 0, the addressed word keeps its value.
- R5: A read request with `rd_en`=1 at a `rd_clk` edge presents the addressed word on `rd_data` right after that edge (one cycle of latency).
- R6: A read port whose `rd_en` was 0 at its last edge drives `rd_data` to all zeros.
- R7: A read of an address that is written on the same clock edge returns the value stored before that write.
- R8: While `rst` is 1 at a read clock edge, that port's `rd_data` becomes all zeros. Stored contents are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset of the read output registers |
| rd_clk | input | N_RD | One clock per read port |
| rd_en | input | N_RD | Read request per port |
| rd_addr | input | N_RD x AW | Read address per port |
| rd_data | output | N_RD x DW | Registered read data per port, zero when not requested |
| wr_clk | input | N_GRP | One clock per write group, selected by `WR_GROUP` |
| wr_en | input | N_WR | Write enable per port |
| wr_mask | input | N_WR | Write mask per port, must be 1 together with the enable |
| wr_addr | input | N_WR x AW | Write address per port |
| wr_data | input | N_WR x DW | Write data per port |

## Verification
The bench writes single ports to confirm that plain storage works. It then drives two same-group ports onto one address, which shows whether the highest-index rule holds or the ports were merged in the wrong order. It drives the same two ports onto different addresses, which shows whether a merged update drops a port's write. Ports from different groups write one address in alternating order, which shows whether a fixed cross-group priority has crept in. A gated write with only one of enable and mask high must leave an earlier value visible. A read that coincides with a write on the same edge must return the old word.

// File: rtl/mwm_pkg.sv
`timescale 1ns/1ps
package mwm_pkg;
  // Number of independent storage lanes: one per clock group when writes
  // are ordered, one per write port otherwise.
  function automatic int lane_count(bit ordered, int n_grp, int n_wr);
    return ordered ? n_grp : n_wr;
  endfunction

  // Bits needed to name a lane in the live-value tag.
  function automatic int tag_width(int n_lane);
    return (n_lane > 1) ? $clog2(n_lane) : 1;
  endfunction
endpackage

// File: rtl/mwm_tagsum.sv
`timescale 1ns/1ps
// Combines the per-lane tag tables: the owning lane of an address is the
// sum of all lane tags modulo the lane count; each lane also receives the
// sum of the other lanes so it can make itself the owner on a write.
module mwm_tagsum #(
  parameter int NL    = 2,
  parameter int DEPTH = 16,
  parameter int TW    = 1
) (
  input  logic [NL-1:0][DEPTH-1:0][TW-1:0] tags,
  output logic [DEPTH-1:0][TW-1:0]         owner,
  output logic [NL-1:0][DEPTH-1:0][TW-1:0] others
);
  always_comb begin
    int s;
    for (int a = 0; a < DEPTH; a++) begin
      s = 0;
      for (int l = 0; l < NL; l++) s += int'(tags[l][a]);
      owner[a] = TW'(s % NL);
      for (int l = 0; l < NL; l++) others[l][a] = TW'((s - int'(tags[l][a])) % NL);
    end
  end
endmodule

// File: rtl/mwm_lane.sv
`timescale 1ns/1ps
// One storage lane: a bank written by the write ports it owns, all on one
// clock. Owned ports are visited in ascending index, so with non-blocking
// updates the highest-index port wins a same-address collision.
module mwm_lane #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int NWR   = 3,
  parameter int NL    = 2,
  parameter int TW    = 1,
  parameter int LANE  = 0,
  parameter logic [NWR-1:0] OWN = '1
) (
  input  logic                         clk,
  input  logic [NWR-1:0]               wr_en,
  input  logic [NWR-1:0]               wr_mask,
  input  logic [NWR-1:0][AW-1:0]       wr_addr,
  input  logic [NWR-1:0][DW-1:0]       wr_data,
  input  logic [DEPTH-1:0][TW-1:0]     oth_sum,
  output logic [DEPTH-1:0][DW-1:0]     bank_o,
  output logic [DEPTH-1:0][TW-1:0]     tag_o
);
  always_ff @(posedge clk) begin
    for (int p = 0; p < NWR; p++) begin
      if (OWN[p] && wr_en[p] && wr_mask[p]) begin
        bank_o[wr_addr[p]] <= wr_data[p];
        tag_o[wr_addr[p]]  <= TW'((LANE + NL - int'(oth_sum[wr_addr[p]])) % NL);
      end
    end
  end
endmodule

// File: rtl/mwm_rdport.sv
`timescale 1ns/1ps
// One read port: samples the owning lane's word at its clock edge, so a
// same-edge write is not yet visible; zero when not requested or in reset.
module mwm_rdport #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int NL    = 2,
  parameter int TW    = 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en,
  input  logic [AW-1:0]                    addr,
  input  logic [NL-1:0][DEPTH-1:0][DW-1:0] banks,
  input  logic [DEPTH-1:0][TW-1:0]         owner,
  output logic [DW-1:0]                    data_o
);
  always_ff @(posedge clk) begin
    if (rst)     data_o <= '0;
    else if (en) data_o <= banks[owner[addr]][addr];
    else         data_o <= '0;
  end
endmodule

// File: rtl/mwm_mem.sv
`timescale 1ns/1ps
module mwm_mem #(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int N_RD    = 2,
  parameter int N_WR    = 3,
  parameter int N_GRP   = 2,
  parameter bit ORDERED = 1'b1,
  parameter int unsigned WR_GROUP [N_WR] = '{0, 0, 1}
) (
  input  logic                         rst,
  input  logic [N_RD-1:0]              rd_clk,
  input  logic [N_RD-1:0]              rd_en,
  input  logic [N_RD-1:0][$clog2(DEPTH)-1:0] rd_addr,
  output logic [N_RD-1:0][DW-1:0]      rd_data,
  input  logic [N_GRP-1:0]             wr_clk,
  input  logic [N_WR-1:0]              wr_en,
  input  logic [N_WR-1:0]              wr_mask,
  input  logic [N_WR-1:0][$clog2(DEPTH)-1:0] wr_addr,
  input  logic [N_WR-1:0][DW-1:0]      wr_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int NL = mwm_pkg::lane_count(ORDERED, N_GRP, N_WR);
  localparam int TW = mwm_pkg::tag_width(NL);

  function automatic logic [N_WR-1:0] lane_own(int l);
    logic [N_WR-1:0] m = '0;
    for (int p = 0; p < N_WR; p++)
      if (ORDERED ? (int'(WR_GROUP[p]) == l) : (p == l)) m[p] = 1'b1;
    return m;
  endfunction

  function automatic int lane_clk(int l);
    if (ORDERED) return l;
    return int'(WR_GROUP[l]);
  endfunction

  logic [NL-1:0][DEPTH-1:0][DW-1:0] banks;
  logic [NL-1:0][DEPTH-1:0][TW-1:0] tags;
  logic [NL-1:0][DEPTH-1:0][TW-1:0] others;
  logic [DEPTH-1:0][TW-1:0]         owner;
  logic [NL-1:0]                    lclk;

  mwm_tagsum #(.NL(NL), .DEPTH(DEPTH), .TW(TW)) tagsum_i (
    .tags(tags), .owner(owner), .others(others)
  );

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam int CK = lane_clk(l);
    assign lclk[l] = wr_clk[CK];
    mwm_lane #(
      .DW(DW), .DEPTH(DEPTH), .AW(AW), .NWR(N_WR), .NL(NL), .TW(TW),
      .LANE(l), .OWN(lane_own(l))
    ) lane_i (
      .clk(lclk[l]), .wr_en(wr_en), .wr_mask(wr_mask), .wr_addr(wr_addr),
      .wr_data(wr_data), .oth_sum(others[l]), .bank_o(banks[l]), .tag_o(tags[l])
    );
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    mwm_rdport #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .NL(NL), .TW(TW)) rd_i (
      .clk(rd_clk[r]), .rst(rst), .en(rd_en[r]), .addr(rd_addr[r]),
      .banks(banks), .owner(owner), .data_o(rd_data[r])
    );
  end
endmodule

// File: rtl/mwm_chk.sv
`timescale 1ns/1ps
module mwm_chk #(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int N_RD    = 2,
  parameter int N_WR    = 3,
  parameter int N_GRP   = 2,
  parameter bit ORDERED = 1'b1,
  parameter int unsigned WR_GROUP [N_WR] = '{0, 0, 1},
  parameter int NL      = 2
) (
  input logic                         rst,
  input logic [N_RD-1:0]              rd_clk,
  input logic [N_RD-1:0]              rd_en,
  input logic [N_RD-1:0][DW-1:0]      rd_data,
  input logic [N_GRP-1:0]             wr_clk,
  input logic [N_WR-1:0]              wr_en,
  input logic [N_WR-1:0]              wr_mask,
  input logic [N_WR-1:0][$clog2(DEPTH)-1:0] wr_addr,
  input logic [N_WR-1:0][DW-1:0]      wr_data,
  input logic [NL-1:0][DEPTH-1:0][DW-1:0] banks
);
  function automatic logic [N_WR-1:0] own_of(int l);
    logic [N_WR-1:0] m = '0;
    for (int p = 0; p < N_WR; p++)
      if (ORDERED ? (int'(WR_GROUP[p]) == l) : (p == l)) m[p] = 1'b1;
    return m;
  endfunction

  function automatic int clk_of(int l);
    if (ORDERED) return l;
    return int'(WR_GROUP[l]);
  endfunction

  for (genvar r = 0; r < N_RD; r++) begin : g_rchk
    assert_reset_clears_R8: assert property (@(posedge rd_clk[r]) disable iff (rst)
      $past(rst) |-> rd_data[r] == '0);
    assert_idle_zero_R6: assert property (@(posedge rd_clk[r]) disable iff (rst)
      !rd_en[r] |=> rd_data[r] == '0);
  end

  for (genvar l = 0; l < NL; l++) begin : g_wchk
    localparam logic [N_WR-1:0] OWN = own_of(l);
    localparam int CK = clk_of(l);
    for (genvar q = 0; q < N_WR; q++) begin : g_port
      if (OWN[q]) begin : g_own
        logic win, idle;
        always_comb begin
          win  = wr_en[q] && wr_mask[q];
          idle = !(wr_en[q] && wr_mask[q]);
          for (int k = 0; k < N_WR; k++) begin
            if (OWN[k] && k > q && wr_en[k] && wr_mask[k] && wr_addr[k] == wr_addr[q])
              win = 1'b0;
            if (OWN[k] && k != q && wr_en[k] && wr_mask[k])
              idle = 1'b0;
          end
        end
        // R1 (highest index wins) and R4 (enabled, masked write lands)
        assert_top_index_wins_R1: assert property (@(posedge wr_clk[CK]) disable iff (rst)
          win |=> banks[l][$past(wr_addr[q])] == $past(wr_data[q]));
        assert_gated_write_holds_R4: assert property (@(posedge wr_clk[CK]) disable iff (rst)
          idle |=> banks[l][$past(wr_addr[q])] == $past(banks[l][wr_addr[q]]));
      end
    end
  end
endmodule

bind mwm_mem mwm_chk #(
  .DW(DW), .DEPTH(DEPTH), .N_RD(N_RD), .N_WR(N_WR), .N_GRP(N_GRP),
  .ORDERED(ORDERED), .WR_GROUP(WR_GROUP), .NL(NL)
) chk_i (
  .rst(rst), .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data),
  .wr_clk(wr_clk), .wr_en(wr_en), .wr_mask(wr_mask), .wr_addr(wr_addr),
  .wr_data(wr_data), .banks(banks)
);

// File: tb/mwm_mem_tb_top.sv
`timescale 1ns/1ps
module mwm_mem_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0]      rd_en = '0;
  logic [1:0][3:0] rd_addr = '0;
  logic [1:0][7:0] rd_data, u_rd_data;
  logic [2:0]      wr_en = '0, wr_mask = '0;
  logic [2:0][3:0] wr_addr = '0;
  logic [2:0][7:0] wr_data = '0;
  logic [1:0]      rclk, wclk;
  assign rclk = {clk, clk};
  assign wclk = {clk, clk};

  // Ports 0 and 1 form group 0, port 2 is group 1.
  mwm_mem dut_i (
    .rst(rst), .rd_clk(rclk), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_clk(wclk), .wr_en(wr_en), .wr_mask(wr_mask), .wr_addr(wr_addr), .wr_data(wr_data)
  );
  mwm_mem #(.ORDERED(1'b0)) dut_u_i (
    .rst(rst), .rd_clk(rclk), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(u_rd_data),
    .wr_clk(wclk), .wr_en(wr_en), .wr_mask(wr_mask), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  typedef struct packed {
    logic [2:0]      en;
    logic [2:0]      msk;
    logic [2:0][3:0] ad;
    logic [2:0][7:0] dt;
    logic [3:0]      ra;
    logic [7:0]      ex;
    logic            chku;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'b001, 3'b001, {4'd0, 4'd0, 4'd1}, {8'd0, 8'd0, 8'h11}, 4'd1, 8'h11, 1'b1}, // R5 plain write
    '{3'b011, 3'b011, {4'd0, 4'd2, 4'd2}, {8'd0, 8'h22, 8'h21}, 4'd2, 8'h22, 1'b0}, // R1 collision
    '{3'b001, 3'b000, {4'd0, 4'd0, 4'd1}, {8'd0, 8'd0, 8'h99}, 4'd1, 8'h11, 1'b1}, // R4 mask low
    '{3'b000, 3'b010, {4'd0, 4'd1, 4'd0}, {8'd0, 8'h98, 8'd0}, 4'd1, 8'h11, 1'b1}, // R4 enable low
    '{3'b100, 3'b100, {4'd3, 4'd0, 4'd0}, {8'h33, 8'd0, 8'd0}, 4'd3, 8'h33, 1'b1}, // R3 group 1
    '{3'b001, 3'b001, {4'd0, 4'd0, 4'd3}, {8'd0, 8'd0, 8'h44}, 4'd3, 8'h44, 1'b1}, // R3 lower index later
    '{3'b100, 3'b100, {4'd3, 4'd0, 4'd0}, {8'h55, 8'd0, 8'd0}, 4'd3, 8'h55, 1'b1}, // R3 back to group 1
    '{3'b011, 3'b011, {4'd0, 4'd5, 4'd4}, {8'd0, 8'h77, 8'h66}, 4'd4, 8'h66, 1'b1}, // R1 R2 distinct addrs
    '{3'b000, 3'b000, {4'd0, 4'd0, 4'd0}, {8'd0, 8'd0, 8'd0},   4'd5, 8'h77, 1'b1}  // R2 second port landed
  };

  int nchk = 0, nfail = 0;

  task automatic chk(string rq, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", rq, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    // R8: reset with read requested gives zero output
    rd_en = 2'b11;
    repeat (3) @(negedge clk);
    chk("R8 port0 reset", rd_data[0], 8'h00);
    chk("R8 port1 reset", rd_data[1], 8'h00);
    rst = 1'b0;
    rd_en = '0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VECS[i].en; wr_mask = VECS[i].msk;
      wr_addr = VECS[i].ad; wr_data = VECS[i].dt;
      @(negedge clk);
      wr_en = '0; wr_mask = '0;
      rd_en[0] = 1'b1; rd_addr[0] = VECS[i].ra;
      @(negedge clk);
      rd_en[0] = 1'b0;
      chk($sformatf("vector %0d ordered", i), rd_data[0], VECS[i].ex);
      if (VECS[i].chku)
        chk($sformatf("vector %0d R2 unordered", i), u_rd_data[0], VECS[i].ex);
    end

    // R5 on port 1, then R6 idle output
    rd_en[1] = 1'b1; rd_addr[1] = 4'd1;
    @(negedge clk);
    chk("R5 port1 latency", rd_data[1], 8'h11);
    rd_en[1] = 1'b0;
    @(negedge clk);
    chk("R6 idle port zero", rd_data[1], 8'h00);

    // R7: read and write of the same address on one edge
    wr_en = 3'b001; wr_mask = 3'b001; wr_addr[0] = 4'd1; wr_data[0] = 8'h12;
    rd_en[0] = 1'b1; rd_addr[0] = 4'd1;
    @(negedge clk);
    wr_en = '0; wr_mask = '0;
    chk("R7 old data on same edge", rd_data[0], 8'h11);
    @(negedge clk);
    chk("R5 new data next edge", rd_data[0], 8'h12);

    // R8: reset during an active read, contents survive
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset mid run", rd_data[0], 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 contents kept", rd_data[0], 8'h12);
    rd_en = '0;

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule